// File: doc/BRIEF.md
# Motor Driver Fault Protection Controller

This block is the digital protection logic of a motor bridge driver. It takes two condition flags from the analog front end: an overcurrent comparator output and an overtemperature indication, which already carries its own hysteresis. It decides when the power stage may switch. It also drives an active-low fault pin and a 16-bit status word that a register bus reads.

Each fault class has its own recovery policy, chosen by a mode input. An overcurrent either stays latched until software clears it, or it retries on its own after a fixed delay. A thermal shutdown either stays latched until a clear that arrives after the die has cooled, or it recovers as soon as the indication drops. The clear command is a single-cycle pulse. It re-enables the bridge at once, so a short that is still present is caught again one deglitch window later. A latched flag never drops just because its condition has gone away.

The logic is meant to run from a 10 MHz clock. The deglitch window and the retry delay are parameters given in cycles, and the retry delay defaults to 40000 cycles (4 ms).

Top module: `drv_fault_guard`

## Requirements
- R1: After reset, `drv_enable_o` is 1, `fault_n_o` is 1 and `status_o` is all zero.
- R2: An overcurrent is registered only at the DEGLITCH_CYC-th consecutive rising clock edge that samples `oc_trip_i` high. Any edge that samples it low restarts the count from zero.
- R3: Once an overcurrent is registered, the next output sample shows `drv_enable_o`=0, `fault_n_o`=0, the OCP bit `status_o[11]`=1 and the FAULT bit `status_o[13]`=1.
- R4: With `oc_retry_mode_i`=0, the OCP and FAULT bits and the disabled outputs stay in place until `clr_fault_i` is sampled high, whether or not `oc_trip_i` is still high.
- R5: An edge that samples `clr_fault_i` high clears the overcurrent state and re-enables the outputs at that edge. If `oc_trip_i` stays high, the overcurrent is registered again DEGLITCH_CYC edges later.
- R6: With `oc_retry_mode_i`=1, a registered overcurrent clears by itself after exactly RETRY_CYC clock cycles, and the cycle repeats while the condition persists.
- R7: An edge that samples `ot_trip_i` high sets the shutdown bit `status_o[9]`, the warning bit `status_o[8]` and FAULT, drives `fault_n_o` low and disables the outputs.
- R8: With `ot_auto_mode_i`=0, the thermal bits stay set after `ot_trip_i` falls. They clear only on an edge that samples `clr_fault_i` high while `ot_trip_i` is low; a clear that arrives while `ot_trip_i` is high has no effect on them.
- R9: With `ot_auto_mode_i`=1, the thermal bits clear and the outputs re-enable on the first edge that samples `ot_trip_i` low.
- R10: `drv_enable_o` is 1 only when neither fault class is active. An active thermal shutdown keeps the outputs off when an overcurrent retry expires.
- R11: All `status_o` bits other than 13, 11, 9 and 8 always read 0, and `fault_n_o` is low exactly when FAULT is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock (10 MHz nominal) |
| rst_n | input | 1 | Asynchronous active-low reset |
| oc_trip_i | input | 1 | Overcurrent comparator flag |
| ot_trip_i | input | 1 | Overtemperature indication with hysteresis |
| oc_retry_mode_i | input | 1 | 0: latch overcurrent, 1: automatic retry |
| ot_auto_mode_i | input | 1 | 0: latch thermal shutdown, 1: automatic recovery |
| clr_fault_i | input | 1 | Single-cycle clear-fault pulse |
| drv_enable_o | output | 1 | Power stage enable |
| fault_n_o | output | 1 | Active-low fault pin |
| status_o | output | 16 | Status word: 13 FAULT, 11 OCP, 9 shutdown, 8 warning |

## Verification
The bench probes the edges of the deglitch window. A comparator pulse one cycle short must not trip, and a dropout of a single cycle must restart the count; an off-by-one counter would trip early or late. It clears while a short is still present and while the die is still hot. A design that cleared the thermal bits on that clear, or that never re-armed the deglitch counter, would leave the bridge running into a fault. It lets a retry expire under an active thermal shutdown, which catches an enable that looks only at the overcurrent class. It also times the retry to the exact cycle and holds latched flags after their conditions vanish.

// File: rtl/dfg_pkg.sv
package dfg_pkg;
    localparam int unsigned STAT_W    = 16;
    localparam int unsigned BIT_FAULT = 13;
    localparam int unsigned BIT_OCP   = 11;
    localparam int unsigned BIT_OTS   = 9;
    localparam int unsigned BIT_TWARN = 8;

    typedef struct packed {
        logic oc_active;
        logic ot_active;
    } fault_sum_t;
endpackage

// File: rtl/dfg_oc_guard.sv
module dfg_oc_guard #(
    parameter int unsigned DEGLITCH_CYC = 30,
    parameter int unsigned RETRY_CYC    = 40000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trip_i,
    input  logic retry_mode_i,
    input  logic clr_i,
    output logic flag_o
);
    localparam int unsigned DG_W = (DEGLITCH_CYC > 1) ? $clog2(DEGLITCH_CYC) : 1;
    localparam int unsigned RT_W = (RETRY_CYC > 1) ? $clog2(RETRY_CYC) : 1;
    localparam logic [DG_W-1:0] DG_LAST = DG_W'(DEGLITCH_CYC - 1);
    localparam logic [RT_W-1:0] RT_LAST = RT_W'(RETRY_CYC - 1);

    typedef struct packed {
        logic            flag;
        logic [DG_W-1:0] dg_cnt;
        logic [RT_W-1:0] rt_cnt;
    } oc_state_t;

    oc_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i) begin
            st_d.flag   = 1'b0;
            st_d.dg_cnt = '0;
            st_d.rt_cnt = '0;
        end else if (st_q.flag) begin
            st_d.dg_cnt = '0;
            if (retry_mode_i) begin
                if (st_q.rt_cnt == RT_LAST) begin
                    st_d.flag   = 1'b0;
                    st_d.rt_cnt = '0;
                end else begin
                    st_d.rt_cnt = st_q.rt_cnt + 1'b1;
                end
            end else begin
                st_d.rt_cnt = '0;
            end
        end else begin
            st_d.rt_cnt = '0;
            if (trip_i) begin
                if (st_q.dg_cnt == DG_LAST) begin
                    st_d.flag   = 1'b1;
                    st_d.dg_cnt = '0;
                end else begin
                    st_d.dg_cnt = st_q.dg_cnt + 1'b1;
                end
            end else begin
                st_d.dg_cnt = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag_o = st_q.flag;
endmodule

// File: rtl/dfg_thermal_guard.sv
module dfg_thermal_guard (
    input  logic clk,
    input  logic rst_n,
    input  logic hot_i,
    input  logic auto_mode_i,
    input  logic clr_i,
    output logic flag_o
);
    typedef struct packed {
        logic flag;
    } ot_state_t;

    ot_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (hot_i) begin
            st_d.flag = 1'b1;
        end else if (st_q.flag && (auto_mode_i || clr_i)) begin
            st_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag_o = st_q.flag;
endmodule

// File: rtl/dfg_status_merge.sv
module dfg_status_merge
    import dfg_pkg::*;
(
    input  fault_sum_t              sum_i,
    output logic                    enable_o,
    output logic                    fault_n_o,
    output logic [STAT_W-1:0]       status_o
);
    logic any_fault;

    assign any_fault = sum_i.oc_active | sum_i.ot_active;
    assign enable_o  = ~any_fault;
    assign fault_n_o = ~any_fault;

    always_comb begin
        status_o            = '0;
        status_o[BIT_FAULT] = any_fault;
        status_o[BIT_OCP]   = sum_i.oc_active;
        status_o[BIT_OTS]   = sum_i.ot_active;
        status_o[BIT_TWARN] = sum_i.ot_active;
    end
endmodule

// File: rtl/drv_fault_guard.sv
module drv_fault_guard
    import dfg_pkg::*;
#(
    parameter int unsigned DEGLITCH_CYC = 30,
    parameter int unsigned RETRY_CYC    = 40000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              oc_trip_i,
    input  logic              ot_trip_i,
    input  logic              oc_retry_mode_i,
    input  logic              ot_auto_mode_i,
    input  logic              clr_fault_i,
    output logic              drv_enable_o,
    output logic              fault_n_o,
    output logic [STAT_W-1:0] status_o
);
    fault_sum_t sum;

    dfg_oc_guard #(
        .DEGLITCH_CYC (DEGLITCH_CYC),
        .RETRY_CYC    (RETRY_CYC)
    ) u_oc (
        .clk          (clk),
        .rst_n        (rst_n),
        .trip_i       (oc_trip_i),
        .retry_mode_i (oc_retry_mode_i),
        .clr_i        (clr_fault_i),
        .flag_o       (sum.oc_active)
    );

    dfg_thermal_guard u_ot (
        .clk         (clk),
        .rst_n       (rst_n),
        .hot_i       (ot_trip_i),
        .auto_mode_i (ot_auto_mode_i),
        .clr_i       (clr_fault_i),
        .flag_o      (sum.ot_active)
    );

    dfg_status_merge u_merge (
        .sum_i     (sum),
        .enable_o  (drv_enable_o),
        .fault_n_o (fault_n_o),
        .status_o  (status_o)
    );
endmodule

// File: rtl/drv_fault_guard_chk.sv
module drv_fault_guard_chk #(
    parameter int unsigned RETRY_CYC = 40000
) (
    input logic        clk,
    input logic        rst_n,
    input logic        oc_trip_i,
    input logic        ot_trip_i,
    input logic        oc_retry_mode_i,
    input logic        ot_auto_mode_i,
    input logic        clr_fault_i,
    input logic        drv_enable_o,
    input logic        fault_n_o,
    input logic [15:0] status_o
);
    localparam int unsigned W = $clog2(RETRY_CYC + 2);
    logic [W-1:0] hi_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                              hi_cnt <= '0;
        else if (!status_o[11] || !oc_retry_mode_i) hi_cnt <= '0;
        else if (hi_cnt <= W'(RETRY_CYC))        hi_cnt <= hi_cnt + 1'b1;
    end

    a_r2_trip_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_o[11]) |-> $past(oc_trip_i));

    a_r4_latched_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o[11] && !oc_retry_mode_i && !clr_fault_i) |=> status_o[11]);

    a_r5_clear_drops_ocp: assert property (@(posedge clk) disable iff (!rst_n)
        clr_fault_i |=> !status_o[11]);

    a_r6_retry_window: assert property (@(posedge clk) disable iff (!rst_n)
        hi_cnt <= W'(RETRY_CYC));

    a_r8_hot_clear_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (ot_trip_i && !ot_auto_mode_i) |=> status_o[9]);

    a_r10_hot_blocks_enable: assert property (@(posedge clk) disable iff (!rst_n)
        ot_trip_i |=> !drv_enable_o);

    a_r11_pin_matches: assert property (@(posedge clk) disable iff (!rst_n)
        fault_n_o == !status_o[13]);
endmodule

bind drv_fault_guard drv_fault_guard_chk #(.RETRY_CYC(RETRY_CYC)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .oc_trip_i       (oc_trip_i),
    .ot_trip_i       (ot_trip_i),
    .oc_retry_mode_i (oc_retry_mode_i),
    .ot_auto_mode_i  (ot_auto_mode_i),
    .clr_fault_i     (clr_fault_i),
    .drv_enable_o    (drv_enable_o),
    .fault_n_o       (fault_n_o),
    .status_o        (status_o)
);

// File: tb/drv_fault_guard_bench.sv
module drv_fault_guard_bench;
    localparam int DG = 8;
    localparam int RT = 50;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic oc_trip = 1'b0, ot_trip = 1'b0, oc_retry = 1'b0, ot_auto = 1'b0, clr = 1'b0;
    logic        en, fault_n;
    logic [15:0] status;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    drv_fault_guard #(.DEGLITCH_CYC(DG), .RETRY_CYC(RT)) u_drv_fault_guard (
        .clk (clk), .rst_n (rst_n), .oc_trip_i (oc_trip), .ot_trip_i (ot_trip),
        .oc_retry_mode_i (oc_retry), .ot_auto_mode_i (ot_auto), .clr_fault_i (clr),
        .drv_enable_o (en), .fault_n_o (fault_n), .status_o (status)
    );

    // Expected status word from the requirement bit positions (R3, R7, R11)
    function automatic logic [15:0] exp_status(input logic oc, input logic ot);
        logic [15:0] s = '0;
        s[13] = oc | ot;
        s[11] = oc;
        s[9]  = ot;
        s[8]  = ot;
        return s;
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Reference state, advanced from the requirements at each edge
    logic m_oc = 1'b0, m_ot = 1'b0;
    int   m_dg = 0, m_rt = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_oc = 1'b0; m_ot = 1'b0; m_dg = 0; m_rt = 0;
        end else begin
            if (clr) begin
                m_oc = 1'b0; m_dg = 0; m_rt = 0;
            end else if (m_oc) begin
                m_dg = 0;
                if (oc_retry) begin
                    if (m_rt == RT - 1) begin m_oc = 1'b0; m_rt = 0; end
                    else m_rt++;
                end else m_rt = 0;
            end else begin
                m_rt = 0;
                if (oc_trip) begin
                    if (m_dg == DG - 1) begin m_oc = 1'b1; m_dg = 0; end
                    else m_dg++;
                end else m_dg = 0;
            end
            if (ot_trip) m_ot = 1'b1;
            else if (m_ot && (ot_auto || clr)) m_ot = 1'b0;
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R10 model enable", {15'd0, en}, {15'd0, !(m_oc | m_ot)});
            check("R11 model status", status, exp_status(m_oc, m_ot));
            check("R11 model pin", {15'd0, fault_n}, {15'd0, !(m_oc | m_ot)});
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_clr();
        clr = 1'b1; step(1); clr = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd1234));
        step(3);
        rst_n = 1'b1;
        step(1);
        check("R1 reset status", status, 16'h0);
        check("R1 reset pins", {14'd0, en, fault_n}, 16'h3);

        // R2: one cycle short, then a dropout
        oc_trip = 1'b1; step(DG - 1);
        check("R2 short pulse", status, 16'h0);
        oc_trip = 1'b0; step(1);
        oc_trip = 1'b1; step(DG - 1);
        check("R2 dropout restarts", status, 16'h0);
        step(1);
        check("R3 detect status", status, exp_status(1, 0));
        check("R3 detect pins", {14'd0, en, fault_n}, 16'h0);

        // R4: latched after short removed
        oc_trip = 1'b0; step(100);
        check("R4 latched hold", status, exp_status(1, 0));

        // R5: clear re-enables; persisting short re-latches
        pulse_clr();
        check("R5 clear", {status[15:1], en}, {exp_status(0, 0)[15:1], 1'b1});
        oc_trip = 1'b1; step(DG);
        check("R5 redetect", status, exp_status(1, 0));
        pulse_clr();
        check("R5 clear under short", status, 16'h0);
        step(DG - 1);
        check("R5 before redetect", status, 16'h0);
        step(1);
        check("R5 relatched", status, exp_status(1, 0));

        // R6: auto retry timing
        pulse_clr(); oc_trip = 1'b0; oc_retry = 1'b1; step(2);
        oc_trip = 1'b1; step(DG); oc_trip = 1'b0;
        check("R6 retry set", status, exp_status(1, 0));
        step(RT - 1);
        check("R6 before expiry", status, exp_status(1, 0));
        step(1);
        check("R6 expired", {15'd0, en}, 16'd1);

        // R10 and R9: thermal holds off past retry expiry, then auto recovers
        ot_auto = 1'b1;
        oc_trip = 1'b1; step(DG); oc_trip = 1'b0;
        ot_trip = 1'b1; step(RT + 2);
        check("R10 ocp retried", {15'd0, status[11]}, 16'd0);
        check("R10 thermal holds off", {15'd0, en}, 16'd0);
        ot_trip = 1'b0; step(1);
        check("R9 auto recover", {status[15:1], en}, {15'd0, 1'b1});

        // R7 and R8: thermal latch
        ot_auto = 1'b0; ot_trip = 1'b1; step(1);
        check("R7 thermal set", status, exp_status(0, 1));
        pulse_clr();
        check("R8 clear while hot ignored", status, exp_status(0, 1));
        ot_trip = 1'b0; step(20);
        check("R8 latched after cooling", status, exp_status(0, 1));
        pulse_clr();
        check("R8 clear after cooling", {status[15:1], en}, {15'd0, 1'b1});

        // Random phase against the reference model
        for (int i = 0; i < 6000; i++) begin
            if ($urandom_range(0, 15) == 0) oc_trip = ~oc_trip;
            ot_trip  = ($urandom_range(0, 99) < 3) ? ~ot_trip : ot_trip;
            if ($urandom_range(0, 199) == 0) oc_retry = ~oc_retry;
            if ($urandom_range(0, 199) == 0) ot_auto  = ~ot_auto;
            clr = ($urandom_range(0, 39) == 0);
            step(1);
        end
        clr = 1'b0;
        step(2);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        #200000;
        n_checks++;
        n_fail++;
        done = 1'b1;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule